// File: doc/BRIEF.md
# Dual-Direction Add-On FIFO Bridge

The block holds two independent first-in first-out buffers between a host-bus side and a local add-on side. The inbound buffer is filled by the host with a single valid strobe and drained by the add-on. The outbound buffer is filled by the add-on and drained by the host. The add-on reaches each buffer through its own active-low strobe. No address, select or byte-enable decode stands in the path.

The add-on always sees two flags: "inbound empty" and "outbound full". A mode input chooses between two configurations. In local-mastering mode (`mst_mode` = 1), two more flags are driven: "inbound full" and "outbound empty". In the same mode, two active-low clear pins reset each buffer's pointers and flags separately. In the other mode the extra flags are held low and the clear pins are ignored. The clears then come from two active-high control bits, which would normally be driven by a register elsewhere.

Both buffers show their oldest word on the read-data output while they hold data. A pop takes effect at the rising clock edge where its strobe is sampled active.

Top module: `addon_fifo_bridge`

## Requirements
- R1: `ao_in_empty` is 1 exactly when the inbound buffer holds zero words, in both modes; after reset it is 1.
- R2: `ao_out_full` is 1 exactly when the outbound buffer holds 8 words, in both modes; after reset it is 0.
- R3: With `mst_mode`=1, `ao_in_full` equals "inbound holds 8 words" and `ao_out_empty` equals "outbound holds zero words". With `mst_mode`=0, both outputs are 0.
- R4: `ao_rd_n` low at a rising edge removes one word from the inbound buffer. `ao_rd_data` shows the oldest stored word, so words leave in the order they arrived.
- R5: `ao_wr_n` low at a rising edge stores `ao_wr_data` in the outbound buffer. `host_out_data` shows the oldest outbound word, and `host_out_pop`=1 removes it.
- R6: `host_in_valid`=1 at a rising edge stores `host_in_data` in the inbound buffer.
- R7: All flags are registered. They take their new value at the same rising edge that accepts the push, pop or clear.
- R8: A pop from an empty buffer and a push into a full buffer are ignored. Stored contents, order and flags are unchanged.
- R9: With `mst_mode`=1, `ao_clr_in_n` low empties only the inbound buffer and `ao_clr_out_n` low empties only the outbound buffer. The other buffer keeps its words.
- R10: With `mst_mode`=0, the clear pins have no effect. `reg_clr_in`=1 empties the inbound buffer and `reg_clr_out`=1 empties the outbound buffer.
- R11: A clear in the same cycle as a push or pop on that buffer acts as the clear alone. The buffer is empty afterwards, and the next word pushed is the first one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_mode | input | 1 | 1 = local-mastering mode (extra flags and clear pins active) |
| host_in_valid | input | 1 | Host push strobe, inbound buffer |
| host_in_data | input | 32 | Host write data, inbound buffer |
| host_out_pop | input | 1 | Host pop strobe, outbound buffer |
| host_out_data | output | 32 | Oldest outbound word |
| reg_clr_in | input | 1 | Control-bit clear of inbound buffer (mode 0) |
| reg_clr_out | input | 1 | Control-bit clear of outbound buffer (mode 0) |
| ao_rd_n | input | 1 | Add-on active-low pop strobe, inbound buffer |
| ao_rd_data | output | 32 | Oldest inbound word |
| ao_wr_n | input | 1 | Add-on active-low push strobe, outbound buffer |
| ao_wr_data | input | 32 | Add-on write data, outbound buffer |
| ao_in_empty | output | 1 | Inbound buffer empty |
| ao_out_full | output | 1 | Outbound buffer full |
| ao_in_full | output | 1 | Inbound buffer full (mode 1 only, else 0) |
| ao_out_empty | output | 1 | Outbound buffer empty (mode 1 only, else 0) |
| ao_clr_in_n | input | 1 | Active-low inbound clear (mode 1 only) |
| ao_clr_out_n | input | 1 | Active-low outbound clear (mode 1 only) |

## Verification
The assertions assume that `mst_mode` is static between clears and that all strobes are synchronous to `clk`. They do not assume that strobes respect the flags. Pushes into a full buffer and pops from an empty one are legal inputs that the design must ignore. The bench changes every input only on the falling edge, holds `mst_mode` constant within each scenario, and applies overflow, underflow and clear-with-strobe collisions deliberately.

// File: rtl/afb_pkg.sv
package afb_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned Q_DEPTH = 8;

  typedef struct packed {
    logic clr;
    logic push;
    logic pop;
  } q_ctl_t;
endpackage

// File: rtl/afb_queue.sv
module afb_queue #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, full_d, empty_q, empty_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push_ok = push & ~full_q & ~clr;
  assign pop_ok  = pop & ~empty_q & ~clr;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = bump(wr_q);
      if (pop_ok)  rd_d = bump(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
    full_d  = (cnt_d == CW'(DEPTH));
    empty_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  assign head_data = mem[rd_q];
  assign full      = full_q;
  assign empty     = empty_q;

  // R7: the two flags never stand together
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));

  // R8: push into a full queue without a pop leaves it full
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full_q && !pop && !clr) |=> (full_q && $stable(wr_q)));

  // R8: pop from an empty queue without a push leaves it empty
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty_q && !push && !clr) |=> (empty_q && $stable(rd_q)));

  // R11: a clear wins over any strobe in the same cycle
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty_q && !full_q));
endmodule

// File: rtl/afb_ctrl.sv
module afb_ctrl (
  input  logic            mst_mode,
  input  logic            host_in_valid,
  input  logic            host_out_pop,
  input  logic            reg_clr_in,
  input  logic            reg_clr_out,
  input  logic            ao_rd_n,
  input  logic            ao_wr_n,
  input  logic            ao_clr_in_n,
  input  logic            ao_clr_out_n,
  input  logic            in_full,
  input  logic            out_empty,
  output afb_pkg::q_ctl_t in_ctl,
  output afb_pkg::q_ctl_t out_ctl,
  output logic            sec_in_full,
  output logic            sec_out_empty
);
  always_comb begin
    in_ctl.clr   = mst_mode ? ~ao_clr_in_n  : reg_clr_in;
    in_ctl.push  = host_in_valid;
    in_ctl.pop   = ~ao_rd_n;
    out_ctl.clr  = mst_mode ? ~ao_clr_out_n : reg_clr_out;
    out_ctl.push = ~ao_wr_n;
    out_ctl.pop  = host_out_pop;
    sec_in_full   = mst_mode & in_full;
    sec_out_empty = mst_mode & out_empty;
  end
endmodule

// File: rtl/addon_fifo_bridge.sv
module addon_fifo_bridge #(
  parameter int unsigned DW    = afb_pkg::WORD_W,
  parameter int unsigned DEPTH = afb_pkg::Q_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mst_mode,
  input  logic          host_in_valid,
  input  logic [DW-1:0] host_in_data,
  input  logic          host_out_pop,
  output logic [DW-1:0] host_out_data,
  input  logic          reg_clr_in,
  input  logic          reg_clr_out,
  input  logic          ao_rd_n,
  output logic [DW-1:0] ao_rd_data,
  input  logic          ao_wr_n,
  input  logic [DW-1:0] ao_wr_data,
  output logic          ao_in_empty,
  output logic          ao_out_full,
  output logic          ao_in_full,
  output logic          ao_out_empty,
  input  logic          ao_clr_in_n,
  input  logic          ao_clr_out_n
);
  afb_pkg::q_ctl_t in_ctl, out_ctl;
  logic in_full, out_empty;

  afb_ctrl u_ctrl (
    .mst_mode      (mst_mode),
    .host_in_valid (host_in_valid),
    .host_out_pop  (host_out_pop),
    .reg_clr_in    (reg_clr_in),
    .reg_clr_out   (reg_clr_out),
    .ao_rd_n       (ao_rd_n),
    .ao_wr_n       (ao_wr_n),
    .ao_clr_in_n   (ao_clr_in_n),
    .ao_clr_out_n  (ao_clr_out_n),
    .in_full       (in_full),
    .out_empty     (out_empty),
    .in_ctl        (in_ctl),
    .out_ctl       (out_ctl),
    .sec_in_full   (ao_in_full),
    .sec_out_empty (ao_out_empty)
  );

  afb_queue #(.DW(DW), .DEPTH(DEPTH)) u_inq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (in_ctl.clr),
    .push      (in_ctl.push),
    .push_data (host_in_data),
    .pop       (in_ctl.pop),
    .head_data (ao_rd_data),
    .full      (in_full),
    .empty     (ao_in_empty)
  );

  afb_queue #(.DW(DW), .DEPTH(DEPTH)) u_outq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (out_ctl.clr),
    .push      (out_ctl.push),
    .push_data (ao_wr_data),
    .pop       (out_ctl.pop),
    .head_data (host_out_data),
    .full      (ao_out_full),
    .empty     (out_empty)
  );

  // R3: in mode 1 the extra flags track the queues, in mode 0 they stay low
  a_r3_secondary_flags: assert property (@(posedge clk) disable iff (!rst_n)
    mst_mode ? (ao_in_full == in_full && ao_out_empty == out_empty)
             : (!ao_in_full && !ao_out_empty));

  // R9: an inbound pin clear leaves a non-empty outbound queue non-empty
  a_r9_clear_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_mode && !ao_clr_in_n && ao_clr_out_n && !out_empty && !host_out_pop)
      |=> !out_empty);
endmodule

// File: tb/addon_fifo_bridge_tb.sv
`timescale 1ns/1ps
module addon_fifo_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mst_mode, host_in_valid, host_out_pop, reg_clr_in, reg_clr_out;
  logic        ao_rd_n, ao_wr_n, ao_clr_in_n, ao_clr_out_n;
  logic [31:0] host_in_data, ao_wr_data, host_out_data, ao_rd_data;
  logic        ao_in_empty, ao_out_full, ao_in_full, ao_out_empty;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  addon_fifo_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .mst_mode(mst_mode),
    .host_in_valid(host_in_valid), .host_in_data(host_in_data),
    .host_out_pop(host_out_pop), .host_out_data(host_out_data),
    .reg_clr_in(reg_clr_in), .reg_clr_out(reg_clr_out),
    .ao_rd_n(ao_rd_n), .ao_rd_data(ao_rd_data),
    .ao_wr_n(ao_wr_n), .ao_wr_data(ao_wr_data),
    .ao_in_empty(ao_in_empty), .ao_out_full(ao_out_full),
    .ao_in_full(ao_in_full), .ao_out_empty(ao_out_empty),
    .ao_clr_in_n(ao_clr_in_n), .ao_clr_out_n(ao_clr_out_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_in_valid = 0; host_out_pop = 0; reg_clr_in = 0; reg_clr_out = 0;
    ao_rd_n = 1; ao_wr_n = 1; ao_clr_in_n = 1; ao_clr_out_n = 1;
  endtask

  // one clock: drive before, sample at the following falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic host_push(input logic [31:0] d);
    host_in_valid = 1; host_in_data = d; step();
  endtask

  task automatic ao_write(input logic [31:0] d);
    ao_wr_n = 0; ao_wr_data = d; step();
  endtask

  task automatic t_reset();
    check("R1 reset in_empty", ao_in_empty, 1);
    check("R2 reset out_full", ao_out_full, 0);
    check("R3 reset out_empty", ao_out_empty, 1);
    check("R3 reset in_full", ao_in_full, 0);
  endtask

  task automatic t_inbound_order();
    host_push(32'hA0);
    check("R7 R6 empty drops after push edge", ao_in_empty, 0);
    host_push(32'hA1);
    host_push(32'hA2);
    for (int i = 0; i < 3; i++) begin
      check("R4 inbound order", ao_rd_data, 32'hA0 + i);
      ao_rd_n = 0; step();
    end
    check("R1 empty after draining", ao_in_empty, 1);
    ao_rd_n = 0; step();
    check("R8 pop from empty keeps empty", ao_in_empty, 1);
    host_push(32'hB7);
    check("R8 underflow did not move pointer", ao_rd_data, 32'hB7);
    ao_rd_n = 0; step();
  endtask

  task automatic t_outbound_fill();
    for (int i = 0; i < 8; i++) begin
      check("R2 not full before 8", ao_out_full, 0);
      ao_write(32'hC0 + i);
    end
    check("R2 full at 8", ao_out_full, 1);
    check("R3 out_empty low when holding", ao_out_empty, 0);
    ao_write(32'hDEAD);
    check("R8 full stays full", ao_out_full, 1);
    for (int i = 0; i < 8; i++) begin
      check("R5 outbound order", host_out_data, 32'hC0 + i);
      host_out_pop = 1; step();
    end
    check("R8 overflow word absent", ao_out_empty, 1);
  endtask

  task automatic t_inbound_full();
    for (int i = 0; i < 8; i++) host_push(32'h10 + i);
    check("R3 in_full in mode 1", ao_in_full, 1);
    ao_clr_in_n = 0; step();
    check("R9 inbound cleared", ao_in_empty, 1);
    check("R9 in_full cleared", ao_in_full, 0);
  endtask

  task automatic t_isolated_clear();
    host_push(32'h21); host_push(32'h22);
    ao_write(32'h31); ao_write(32'h32);
    ao_clr_in_n = 0; step();
    check("R9 inbound empty", ao_in_empty, 1);
    check("R9 outbound kept", ao_out_empty, 0);
    check("R9 outbound head kept", host_out_data, 32'h31);
    ao_clr_out_n = 0; step();
    check("R9 outbound cleared", ao_out_empty, 1);
  endtask

  task automatic t_clear_collide();
    host_in_valid = 1; host_in_data = 32'h77; ao_clr_in_n = 0; step();
    check("R11 clear beats push", ao_in_empty, 1);
    host_push(32'h41); host_push(32'h42);
    ao_rd_n = 0; ao_clr_in_n = 0; step();
    check("R11 clear beats pop", ao_in_empty, 1);
    host_push(32'h55);
    check("R11 pointers reset", ao_rd_data, 32'h55);
    ao_rd_n = 0; step();
  endtask

  task automatic t_mode0();
    mst_mode = 0;
    for (int i = 0; i < 8; i++) host_push(32'h60 + i);
    check("R3 in_full hidden in mode 0", ao_in_full, 0);
    check("R3 out_empty hidden in mode 0", ao_out_empty, 0);
    ao_clr_in_n = 0; step();
    check("R10 pin clear ignored", ao_in_empty, 0);
    check("R10 head unchanged", ao_rd_data, 32'h60);
    ao_write(32'h91);
    ao_clr_out_n = 0; step();
    check("R10 out pin clear ignored", host_out_data, 32'h91);
    reg_clr_in = 1; step();
    check("R10 reg clear in", ao_in_empty, 1);
    check("R2 out not full", ao_out_full, 0);
    reg_clr_out = 1; step();
    ao_write(32'h92);
    check("R10 reg clear out", host_out_data, 32'h92);
    mst_mode = 1;
    ao_clr_out_n = 0; step();
  endtask

  initial begin
    rst_n = 0; mst_mode = 1; host_in_data = '0; ao_wr_data = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_inbound_order();
    t_outbound_fill();
    t_inbound_full();
    t_isolated_clear();
    t_clear_collide();
    t_mode0();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule